// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command (a read or a write) into the sequence of column addresses that an SDRAM burst visits. A controller pulses `start_i` with the first column and the mode settings it has programmed. The generator then shows one column per clock on `col_o`, qualified by `valid_o`, and raises `last_o` on the final beat. The data path and the CAS-latency delay sit outside this block. They consume the column stream.

Bursts of 1, 2, 4 and 8 beats stay inside their aligned block. They follow either an incrementing order or an XOR order. A full-page burst runs through every column of the row, wrapping from the top column to zero, until a stop ends it. A single-beat write setting cuts writes to one beat and leaves reads alone. A stop request or a fresh column command cuts a burst short.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `valid_o`=0, `last_o`=0 and `col_o`=0.
- R2: A `start_i` sampled high puts beat 0 on the outputs after that edge, with `col_o` equal to `start_col_i`. Each later beat follows on the next clock, with `valid_o` high and no gaps.
- R3: Burst length code `blen_code_i` selects the beat count: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 behave as a one-beat burst.
- R4: When `ilv_i`=0, beat k carries the low log2(L) bits of (start + k) modulo L, where L is the burst length.
- R5: When `ilv_i`=1 and the burst is not full page, beat k carries the low log2(L) bits of (start XOR k).
- R6: In a burst that is not full page, the column bits above the burst-length field equal those of the start column on every beat.
- R7: A full-page burst (code 7) always increments, whatever `ilv_i` is. It wraps from column 2^COL_W-1 to 0 and continues with `last_o` low until it is stopped.
- R8: `last_o` is high on the final beat only. If no new start is sampled, `valid_o` is low on the cycle after the final beat.
- R9: A start with `wr_i`=1 and `single_wr_i`=1 gives a one-beat burst with `last_o` high, for any code. Reads ignore `single_wr_i`.
- R10: If `stop_i` is sampled high while a beat that is not the last is shown (and `start_i` is low), the next beat is the final one. On a last beat, or while idle, `stop_i` has no effect.
- R11: A `start_i` during a burst restarts the generator from the new column on the next beat. When both arrive together, the start takes priority over `stop_i`.
- R12: While `valid_o` is low after a burst, `col_o` keeps the column of the last beat shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Column command accepted this cycle |
| start_col_i | input | COL_W | First column of the burst |
| blen_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 = incrementing order, 1 = XOR order |
| wr_i | input | 1 | Command is a write |
| single_wr_i | input | 1 | Writes limited to one beat |
| stop_i | input | 1 | Request to end the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | The presented beat is the final one |

## Verification
The bench builds the block with the default COL_W of 8, so a full page is 256 columns. This width is small enough that a full-page burst started near the top column wraps to zero within a few beats. The bench watches that wrap and then stops the burst. Start columns are chosen with their low bits near the end of the 4- and 8-beat blocks, so both the wrap of the incrementing order and the XOR order carry into the upper column bits that must stay fixed.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  // Burst length codes as presented on blen_code_i
  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;

  // Ordering applied to the low column bits
  typedef enum logic {
    ORD_INCR = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;

endpackage

// File: rtl/sdram_bl_decode.sv
module sdram_bl_decode
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);

  logic one_beat_wr;

  assign one_beat_wr = wr_i & single_wr_i;

  always_comb begin
    page_o = 1'b0;
    mask_o = '0;
    if (!one_beat_wr) begin
      unique case (code_i)
        BLC_2:    mask_o = COL_W'(1);
        BLC_4:    mask_o = COL_W'(3);
        BLC_8:    mask_o = COL_W'(7);
        BLC_PAGE: begin
          mask_o = '1;
          page_o = 1'b1;
        end
        default:  mask_o = '0;  // code 0 and reserved codes: one beat
      endcase
    end
  end

endmodule

// File: rtl/sdram_col_order.sv
module sdram_col_order
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] beat_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] incr_col;
  logic [COL_W-1:0] xor_col;

  assign incr_col = base_i + beat_i;
  assign xor_col  = base_i ^ beat_i;

  // Bits inside the burst field move; bits above it stay at the base column.
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? ((order_i == ORD_XOR) ? xor_col[b] : incr_col[b])
                                : base_i[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_code_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] base_q, mask_q, beat_q;
  order_e           order_q;
  logic             page_q;

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic [COL_W-1:0] beat_nx;
  logic [COL_W-1:0] ord_col;
  logic             more;

  sdram_bl_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (blen_code_i),
    .wr_i        (wr_i),
    .single_wr_i (single_wr_i),
    .mask_o      (dec_mask),
    .page_o      (dec_page)
  );

  assign beat_nx = beat_q + ONE;
  assign more    = valid_o & ~last_o;

  sdram_col_order #(.COL_W(COL_W)) u_ord (
    .base_i  (base_q),
    .mask_i  (mask_q),
    .beat_i  (beat_nx),
    .order_i (order_q),
    .col_o   (ord_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      order_q <= ORD_INCR;
      page_q  <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      mask_q  <= dec_mask;
      beat_q  <= '0;
      order_q <= (ilv_i && !dec_page) ? ORD_XOR : ORD_INCR;
      page_q  <= dec_page;
      col_o   <= start_col_i;
      valid_o <= 1'b1;
      last_o  <= (dec_mask == '0);
    end else if (more) begin
      beat_q  <= beat_nx;
      col_o   <= ord_col;
      valid_o <= 1'b1;
      last_o  <= stop_i | (!page_q && (beat_nx == mask_q));
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && !last_o && col_o == '0));

  p_start_col_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !$past(rst)) |=> (valid_o && col_o == $past(start_col_i)));

  p_beat_in_block_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !page_q) |-> ((beat_q & ~mask_q) == '0));

  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !page_q && !start_i && !last_o) |=>
      ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

  p_page_incr_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && page_q && !last_o && !start_i) |=> (col_o == $past(col_o) + ONE));

  p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  p_last_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  p_single_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && wr_i && single_wr_i) |=> (valid_o && last_o));

  p_stop_final_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && stop_i && !start_i) |=> (valid_o && last_o));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start_i) |=> $stable(col_o));

endmodule

// File: tb/test_sdram_burst_colgen.sv
`timescale 1ns/1ps
module test_sdram_burst_colgen;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       blen_code_i;
  logic             ilv_i, wr_i, single_wr_i, stop_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  sdram_burst_colgen #(.COL_W(COL_W)) i_sdram_burst_colgen (
    .clk, .rst, .start_i, .start_col_i, .blen_code_i, .ilv_i,
    .wr_i, .single_wr_i, .stop_i, .col_o, .valid_o, .last_o
  );

  typedef struct packed {
    logic [7:0] col;
    logic [2:0] code;
    logic       ilv;
    logic       wr;
    logic       single;
    logic [8:0] n;
    logic [7:0] c1;
    logic [7:0] c2;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h15, 3'd2, 1'b0, 1'b0, 1'b0, 9'd4, 8'h16, 8'h17},
    '{8'h15, 3'd2, 1'b1, 1'b0, 1'b0, 9'd4, 8'h14, 8'h17},
    '{8'h3E, 3'd3, 1'b0, 1'b0, 1'b0, 9'd8, 8'h3F, 8'h38},
    '{8'h3E, 3'd3, 1'b1, 1'b0, 1'b0, 9'd8, 8'h3F, 8'h3C},
    '{8'h81, 3'd1, 1'b0, 1'b0, 1'b0, 9'd2, 8'h80, 8'h00},
    '{8'h81, 3'd1, 1'b1, 1'b0, 1'b0, 9'd2, 8'h80, 8'h00},
    '{8'h47, 3'd0, 1'b0, 1'b0, 1'b0, 9'd1, 8'h00, 8'h00},
    '{8'h22, 3'd5, 1'b0, 1'b0, 1'b0, 9'd1, 8'h00, 8'h00},
    '{8'hAA, 3'd6, 1'b1, 1'b0, 1'b0, 9'd1, 8'h00, 8'h00},
    '{8'h33, 3'd3, 1'b0, 1'b1, 1'b1, 9'd1, 8'h00, 8'h00},
    '{8'h90, 3'd7, 1'b0, 1'b1, 1'b1, 9'd1, 8'h00, 8'h00},
    '{8'h10, 3'd3, 1'b0, 1'b0, 1'b1, 9'd8, 8'h11, 8'h12},
    '{8'h02, 3'd2, 1'b1, 1'b1, 1'b0, 9'd4, 8'h03, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Column expected for beat k of a bounded burst of n beats (R4, R5, R6)
  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic x, input int n, input int k);
    logic [7:0] m, kk;
    m  = 8'(n - 1);
    kk = 8'(k);
    return x ? ((s & ~m) | ((s ^ kk) & m)) : ((s & ~m) | ((s + kk) & m));
  endfunction

  task automatic drive_start(input logic [7:0] c, input logic [2:0] code, input logic x,
                             input logic w, input logic sw);
    start_i = 1'b1; start_col_i = c; blen_code_i = code;
    ilv_i = x; wr_i = w; single_wr_i = sw;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; start_col_i = '0; blen_code_i = '0;
    ilv_i = 1'b0; wr_i = 1'b0; single_wr_i = 1'b0; stop_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid", 32'(valid_o), 0);
    chk(last_o == 1'b0,  "R1 last",  32'(last_o), 0);
    chk(col_o == 8'h00,  "R1 col",   32'(col_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // Vector table: R2 R3 R4 R5 R6 R8 R9 R12
    for (int v = 0; v < NV; v++) begin
      logic [7:0] lastc;
      drive_start(VECS[v].col, VECS[v].code, VECS[v].ilv, VECS[v].wr, VECS[v].single);
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < int'(VECS[v].n); k++) begin
        lastc = exp_col(VECS[v].col, VECS[v].ilv, int'(VECS[v].n), k);
        chk(valid_o == 1'b1, $sformatf("R2 vec%0d beat%0d valid", v, k), 32'(valid_o), 1);
        chk(col_o == lastc, $sformatf("R4/R5 vec%0d beat%0d col", v, k), 32'(col_o), 32'(lastc));
        chk(last_o == (k == int'(VECS[v].n) - 1), $sformatf("R8 vec%0d beat%0d last", v, k),
            32'(last_o), 32'(k == int'(VECS[v].n) - 1));
        if (k == 1) chk(col_o == VECS[v].c1, $sformatf("R6 vec%0d beat1", v), 32'(col_o), 32'(VECS[v].c1));
        if (k == 2) chk(col_o == VECS[v].c2, $sformatf("R6 vec%0d beat2", v), 32'(col_o), 32'(VECS[v].c2));
        @(negedge clk);
      end
      chk(valid_o == 1'b0, $sformatf("R3 vec%0d length end", v), 32'(valid_o), 0);
      chk(col_o == lastc, $sformatf("R12 vec%0d hold", v), 32'(col_o), 32'(lastc));
    end

    // R7 full page wraps and ignores ilv_i; R10 stop ends it
    drive_start(8'hFC, 3'd7, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk(col_o == 8'(8'hFC + k), $sformatf("R7 page beat%0d col", k), 32'(col_o), 32'(8'(8'hFC + k)));
      chk(valid_o && !last_o, $sformatf("R7 page beat%0d no last", k), 32'({valid_o, last_o}), 2);
      if (k == 5) stop_i = 1'b1;
      @(negedge clk);
    end
    stop_i = 1'b0;
    chk(col_o == 8'h02, "R10 page stop col", 32'(col_o), 2);
    chk(valid_o && last_o, "R10 page stop last", 32'({valid_o, last_o}), 3);
    @(negedge clk);
    chk(!valid_o && !last_o, "R8 page ended", 32'({valid_o, last_o}), 0);
    chk(col_o == 8'h02, "R12 page hold", 32'(col_o), 2);

    // R10 stop in a bounded burst
    drive_start(8'h00, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(col_o == 8'h01 && !last_o, "R10 pre-stop beat", 32'(col_o), 1);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(col_o == 8'h02 && last_o && valid_o, "R10 stopped final", 32'({col_o, last_o}), 32'h5);
    @(negedge clk);
    chk(!valid_o, "R10 ended after stop", 32'(valid_o), 0);

    // R10 stop on last beat has no effect
    drive_start(8'h10, 3'd1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(last_o && col_o == 8'h11, "R10 last beat", 32'({col_o, last_o}), 32'h23);
    stop_i = 1'b1;
    @(negedge clk);
    chk(!valid_o && !last_o, "R10 stop on last ignored", 32'({valid_o, last_o}), 0);
    // R10 stop while idle
    @(negedge clk);
    stop_i = 1'b0;
    chk(!valid_o && col_o == 8'h11, "R10 idle stop ignored", 32'({valid_o, col_o}), 32'h11);

    // R11 restart during a burst, start wins over stop
    drive_start(8'h20, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(col_o == 8'h22, "R11 before restart", 32'(col_o), 32'h22);
    drive_start(8'h55, 3'd1, 1'b0, 1'b0, 1'b0);
    stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    chk(valid_o && !last_o && col_o == 8'h55, "R11 restart beat0", 32'({last_o, col_o}), 32'h55);
    @(negedge clk);
    chk(valid_o && last_o && col_o == 8'h54, "R11 restart beat1", 32'({last_o, col_o}), 32'h154);
    @(negedge clk);
    chk(!valid_o, "R11 restart ended", 32'(valid_o), 0);

    // R1 reset in mid burst
    drive_start(8'h70, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(!valid_o && !last_o && col_o == 8'h00, "R1 mid-burst reset",
        32'({valid_o, last_o, col_o}), 0);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule